// File: doc/BRIEF.md
# Capture Input Conditioner

This block prepares up to three capture inputs for a timer. Each channel picks its raw signal from a device pin or from a quadrature encoder line. Channel 0 takes encoder phase A, channel 1 takes phase B and channel 2 takes the index line. The chosen signal passes through a two-flop synchronizer and then a majority-free glitch filter. The filter accepts a new level only when three consecutive samples agree. The filter samples on a clock enable that a prescaler derives from the capture clock, and the prescaler rate is shared by all channels. A single control bit bypasses the filter, so that the synchronized signal drives edge detection directly.

Each channel detects rising edges, falling edges or both, as its own edge mode selects, and the result is gated by that channel's enable. The block produces a one-cycle pulse per qualifying transition and drives the conditioned level of every channel out for status readback. Counting, hold registers and flags sit downstream and consume these outputs.

Top module: `capin_conditioner`

## Requirements
- R1: Source select per channel (2 bits): 00 picks the pin, 10 picks the encoder line for that channel (bit 0 phase A, bit 1 phase B, bit 2 index), and the reserved codes 01 and 11 force the channel's signal to a constant 0.
- R2: The filter sample enable runs at the capture clock divided by 1, 2, 4, 16, 32 or 64 for rate codes 000 to 101, and codes 110 and 111 behave as divide by 64. Two sample enables are never adjacent unless the code is 000.
- R3: With the filter active, the level changes only after three consecutive equal samples, so a 2-cycle glitch at divide by 1 is rejected. At divide by 1, a change on the selected input shows on `level` 5 cycles after it is applied, and a 3-cycle pulse is passed.
- R4: With the bypass bit set, a change on the selected input shows on `level` 2 cycles after it is applied, and that delay comes from the synchronizer alone.
- R5: Edge mode per channel (2 bits): 00 reports rising edges only, 01 falling edges only, and 10 or 11 both edges.
- R6: A channel whose enable is 0 never produces a pulse, while its `level` keeps tracking the input.
- R7: Each qualifying transition of the conditioned level gives exactly one `edge_pulse` bit that is high for one clock, in the cycle after `level` changed.
- R8: While reset is asserted and after it is released with all inputs low, `level` and `edge_pulse` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_in | input | NUM_CH | Device pin input per channel |
| enc_sig | input | NUM_CH | Encoder lines: bit 0 phase A, bit 1 phase B, bit 2 index |
| src_sel | input | 2*NUM_CH | Source select, 2 bits per channel |
| flt_rate | input | 3 | Filter sample rate code |
| flt_bypass | input | 1 | 1 bypasses the glitch filter |
| edge_mode | input | 2*NUM_CH | Edge mode, 2 bits per channel |
| ch_en | input | NUM_CH | Per-channel pulse enable |
| edge_pulse | output | NUM_CH | One-cycle valid-edge pulse per channel |
| level | output | NUM_CH | Conditioned level per channel |

## Verification
A faulty prescaler count shows at the ports as a filter delay outside the window that the rate code predicts. The rate tests measure this delay for every code, so the fault is seen within about 200 cycles. Corrupted filter history either lets a 2-cycle glitch reach `level` or delays an accepted change beyond 5 cycles at divide by 1, which is visible within a few cycles of the stimulus. A wrong previous-level register or edge-mode decode gives a pulse that is missing, doubled or a cycle late, and the scoreboard flags it against its expected cycle at the next clock.

// File: rtl/capin_pkg.sv
`timescale 1ns/1ps
package capin_pkg;

  typedef enum logic [1:0] {
    SRC_PIN   = 2'b00,
    SRC_RSV_A = 2'b01,
    SRC_ENC   = 2'b10,
    SRC_RSV_B = 2'b11
  } src_sel_e;

  typedef enum logic [1:0] {
    EDGE_RISE   = 2'b00,
    EDGE_FALL   = 2'b01,
    EDGE_BOTH   = 2'b10,
    EDGE_BOTH_X = 2'b11
  } edge_mode_e;

  localparam int unsigned RATE_W  = 3;
  localparam int unsigned PRESC_W = 6;

  // Terminal count of the prescaler for a rate code (divisor minus one).
  function automatic logic [PRESC_W-1:0] rate_to_limit(input logic [RATE_W-1:0] code);
    logic [PRESC_W-1:0] lim;
    case (code)
      3'd0:    lim = PRESC_W'(0);
      3'd1:    lim = PRESC_W'(1);
      3'd2:    lim = PRESC_W'(3);
      3'd3:    lim = PRESC_W'(15);
      3'd4:    lim = PRESC_W'(31);
      default: lim = PRESC_W'(63);
    endcase
    return lim;
  endfunction

endpackage

// File: rtl/capin_prescaler.sv
`timescale 1ns/1ps
module capin_prescaler import capin_pkg::*; #(
  parameter int unsigned CNT_W = PRESC_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  output logic              tick
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic [CNT_W-1:0] limit;

  // A count at or past the limit ends the period, so a rate change never stalls.
  always_comb begin
    limit = CNT_W'(rate_to_limit(rate));
    tick  = (cnt_q >= limit);
    cnt_d = tick ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/capin_filter.sv
`timescale 1ns/1ps
module capin_filter #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_tick,
  input  logic din,
  output logic dout
);

  localparam int unsigned HW = FILT_LEN - 1;

  logic [HW-1:0] hist_q;
  logic [HW-1:0] hist_d;
  logic [HW:0]   window;
  logic          out_q;
  logic          out_d;

  assign window = {hist_q, din};

  always_comb begin
    hist_d = hist_q;
    out_d  = out_q;
    if (samp_tick) begin
      hist_d = window[HW-1:0];
      if (&window)       out_d = 1'b1;
      else if (~|window) out_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      out_q  <= 1'b0;
    end else begin
      hist_q <= hist_d;
      out_q  <= out_d;
    end
  end

  assign dout = out_q;

endmodule

// File: rtl/capin_channel.sv
`timescale 1ns/1ps
module capin_channel import capin_pkg::*; #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin,
  input  logic       enc,
  input  logic [1:0] src_sel,
  input  logic [1:0] edge_mode,
  input  logic       enable,
  input  logic       bypass,
  input  logic       samp_tick,
  output logic       pulse,
  output logic       level
);

  logic                   raw;
  logic [SYNC_STAGES-1:0] sync_q;
  logic [SYNC_STAGES-1:0] sync_d;
  logic                   synced;
  logic                   filt_lvl;
  logic                   lvl;
  logic                   prev_q;
  logic                   pulse_q;
  logic                   pulse_d;
  logic                   rise;
  logic                   fall;
  logic                   hit;

  // Source choice; reserved codes park the channel low.
  always_comb begin
    case (src_sel_e'(src_sel))
      SRC_PIN: raw = pin;
      SRC_ENC: raw = enc;
      default: raw = 1'b0;
    endcase
  end

  assign sync_d = {sync_q[SYNC_STAGES-2:0], raw};
  assign synced = sync_q[SYNC_STAGES-1];

  capin_filter #(.FILT_LEN(FILT_LEN)) u_filt (
    .clk       (clk),
    .rst_n     (rst_n),
    .samp_tick (samp_tick),
    .din       (synced),
    .dout      (filt_lvl)
  );

  assign lvl = bypass ? synced : filt_lvl;

  always_comb begin
    rise = lvl & ~prev_q;
    fall = ~lvl & prev_q;
    case (edge_mode_e'(edge_mode))
      EDGE_RISE: hit = rise;
      EDGE_FALL: hit = fall;
      default:   hit = rise | fall;
    endcase
    pulse_d = enable & hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      prev_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      sync_q  <= sync_d;
      prev_q  <= lvl;
      pulse_q <= pulse_d;
    end
  end

  assign pulse = pulse_q;
  assign level = lvl;

endmodule

// File: rtl/capin_conditioner.sv
`timescale 1ns/1ps
module capin_conditioner import capin_pkg::*; #(
  parameter int unsigned NUM_CH      = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_CH-1:0]   pin_in,
  input  logic [NUM_CH-1:0]   enc_sig,
  input  logic [2*NUM_CH-1:0] src_sel,
  input  logic [RATE_W-1:0]   flt_rate,
  input  logic                flt_bypass,
  input  logic [2*NUM_CH-1:0] edge_mode,
  input  logic [NUM_CH-1:0]   ch_en,
  output logic [NUM_CH-1:0]   edge_pulse,
  output logic [NUM_CH-1:0]   level
);

  localparam int unsigned RST_STAGES = 2;

  logic [RST_STAGES-1:0] rst_pipe_q;
  logic [RST_STAGES-1:0] rst_pipe_d;
  logic                  core_rst_n;
  logic                  samp_tick;

  // Reset asserts at once and leaves on a clock edge.
  assign rst_pipe_d = {rst_pipe_q[RST_STAGES-2:0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= rst_pipe_d;
  end

  assign core_rst_n = rst_pipe_q[RST_STAGES-1];

  capin_prescaler #(.CNT_W(PRESC_W)) u_presc (
    .clk   (clk),
    .rst_n (core_rst_n),
    .rate  (flt_rate),
    .tick  (samp_tick)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    capin_channel #(
      .SYNC_STAGES (SYNC_STAGES),
      .FILT_LEN    (FILT_LEN)
    ) u_ch (
      .clk       (clk),
      .rst_n     (core_rst_n),
      .pin       (pin_in[g]),
      .enc       (enc_sig[g]),
      .src_sel   (src_sel[2*g +: 2]),
      .edge_mode (edge_mode[2*g +: 2]),
      .enable    (ch_en[g]),
      .bypass    (flt_bypass),
      .samp_tick (samp_tick),
      .pulse     (edge_pulse[g]),
      .level     (level[g])
    );
  end

endmodule

// File: rtl/capin_conditioner_chk.sv
`timescale 1ns/1ps
module capin_conditioner_chk #(
  parameter int unsigned NUM_CH = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic [2:0]          flt_rate,
  input logic                flt_bypass,
  input logic [2*NUM_CH-1:0] edge_mode,
  input logic [NUM_CH-1:0]   ch_en,
  input logic [NUM_CH-1:0]   edge_pulse,
  input logic [NUM_CH-1:0]   level,
  input logic                samp_tick
);

  // R2: outside divide-by-1 a sample enable is always followed by a gap.
  p_tick_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (flt_rate != 3'b000 && $past(samp_tick)) |-> !samp_tick);

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    // R6: pulses only from enabled channels
    p_pulse_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
      edge_pulse[i] |-> $past(ch_en[i]));

    // R7: a pulse follows a level change one cycle later
    p_pulse_on_change_r7: assert property (@(posedge clk) disable iff (!rst_n)
      edge_pulse[i] |-> ($past(level[i]) != $past(level[i], 2)));

    // R5: rising-only mode reports only transitions to 1
    p_rise_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_pulse[i] && $past(edge_mode[2*i +: 2]) == 2'b00) |-> $past(level[i]));

    // R5: falling-only mode reports only transitions to 0
    p_fall_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_pulse[i] && $past(edge_mode[2*i +: 2]) == 2'b01) |-> !$past(level[i]));

    // R3: with the filter in use, the level moves only on a sample enable
    p_filter_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!flt_bypass && !$past(flt_bypass) && level[i] != $past(level[i])) |-> $past(samp_tick));
  end

endmodule

bind capin_conditioner capin_conditioner_chk #(.NUM_CH(NUM_CH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flt_rate   (flt_rate),
  .flt_bypass (flt_bypass),
  .edge_mode  (edge_mode),
  .ch_en      (ch_en),
  .edge_pulse (edge_pulse),
  .level      (level),
  .samp_tick  (samp_tick)
);

// File: tb/capin_conditioner_test.sv
`timescale 1ns/1ps
module capin_conditioner_test;

  localparam int NCH       = 3;
  localparam int BYP_PULSE = 3;
  localparam int FLT_PULSE = 6;

  logic           clk = 1'b0;
  logic           rst_n;
  logic [NCH-1:0] pin_in;
  logic [NCH-1:0] enc_sig;
  logic [2*NCH-1:0] src_sel;
  logic [2:0]     flt_rate;
  logic           flt_bypass;
  logic [2*NCH-1:0] edge_mode;
  logic [NCH-1:0] ch_en;
  logic [NCH-1:0] edge_pulse;
  logic [NCH-1:0] level;

  capin_conditioner uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .pin_in     (pin_in),
    .enc_sig    (enc_sig),
    .src_sel    (src_sel),
    .flt_rate   (flt_rate),
    .flt_bypass (flt_bypass),
    .edge_mode  (edge_mode),
    .ch_en      (ch_en),
    .edge_pulse (edge_pulse),
    .level      (level)
  );

  always #2 clk = ~clk;

  int cyc   = 0;
  int n_vec = 0;
  int n_bad = 0;

  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int ch;
    int at;
  } pulse_t;

  pulse_t exp_q[$];

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_val(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    n_vec++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp_v);
    end
  endtask

  // Called at a negedge right after driving the stimulus.
  task automatic expect_pulse(input int ch, input int lat);
    pulse_t p;
    p.ch = ch;
    p.at = cyc + lat;
    exp_q.push_back(p);
  endtask

  function automatic int bench_div(input int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      3: return 16;
      4: return 32;
      default: return 64;
    endcase
  endfunction

  // Scoreboard monitor (R7): every pulse must match the next expected item.
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      while (exp_q.size() > 0 && exp_q[0].at < cyc) begin
        n_vec++;
        n_bad++;
        $display("FAIL R7: pulse ch%0d missing, actual none, expected at cycle %0d", exp_q[0].ch, exp_q[0].at);
        void'(exp_q.pop_front());
      end
      for (int c = 0; c < NCH; c++) begin
        if (edge_pulse[c] === 1'b1) begin
          pulse_t p;
          n_vec++;
          if (exp_q.size() == 0) begin
            n_bad++;
            $display("FAIL R7: pulse ch%0d cycle %0d, actual 1 expected 0", c, cyc);
          end else begin
            p = exp_q.pop_front();
            if (p.ch != c || p.at != cyc) begin
              n_bad++;
              $display("FAIL R7: actual ch%0d cycle %0d, expected ch%0d cycle %0d", c, cyc, p.ch, p.at);
            end
          end
        end
      end
    end
  end

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual still running, expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    pin_in     = '0;
    enc_sig    = '0;
    src_sel    = '0;
    flt_rate   = 3'b000;
    flt_bypass = 1'b1;
    edge_mode  = {2'b10, 2'b01, 2'b00};
    ch_en      = '1;
    rst_n      = 1'b0;
    idle(3);
    check_val("R8 level in reset", 32'(level), 32'h0);
    check_val("R8 pulse in reset", 32'(edge_pulse), 32'h0);
    rst_n = 1'b1;
    idle(6);
    check_val("R8 level after reset", 32'(level), 32'h0);

    // R4 / R5: bypass, ch0 rising, ch1 falling, ch2 both
    pin_in = 3'b111;
    expect_pulse(0, BYP_PULSE);
    expect_pulse(2, BYP_PULSE);
    idle(1);
    check_val("R4 level not yet", 32'(level), 32'h0);
    idle(1);
    check_val("R4 level after 2 cycles", 32'(level), 32'h7);
    idle(5);
    pin_in = 3'b000;
    expect_pulse(1, BYP_PULSE);
    expect_pulse(2, BYP_PULSE);
    idle(2);
    check_val("R4 level falls", 32'(level), 32'h0);
    idle(5);

    // R5: code 11 on ch0 means both edges
    edge_mode[1:0] = 2'b11;
    idle(2);
    pin_in[0] = 1'b1;
    expect_pulse(0, BYP_PULSE);
    idle(5);
    pin_in[0] = 1'b0;
    expect_pulse(0, BYP_PULSE);
    idle(5);

    // R3: filter at divide by 1
    flt_bypass = 1'b0;
    idle(3);
    pin_in[0] = 1'b1;
    expect_pulse(0, FLT_PULSE);
    idle(4);
    check_val("R3 level held before third sample", 32'(level[0]), 32'h0);
    idle(1);
    check_val("R3 level after 5 cycles", 32'(level[0]), 32'h1);
    idle(5);
    pin_in[0] = 1'b0;
    expect_pulse(0, FLT_PULSE);
    idle(8);
    check_val("R3 level falls", 32'(level[0]), 32'h0);

    // R3: 2-cycle glitch rejected, 3-cycle pulse passed
    pin_in[2] = 1'b1;
    idle(2);
    pin_in[2] = 1'b0;
    idle(10);
    check_val("R3 short glitch rejected", 32'(level[2]), 32'h0);
    pin_in[2] = 1'b1;
    expect_pulse(2, FLT_PULSE);
    idle(3);
    pin_in[2] = 1'b0;
    expect_pulse(2, FLT_PULSE);
    idle(2);
    check_val("R3 three-sample pulse passed", 32'(level[2]), 32'h1);
    idle(8);

    // R1: source selection in bypass
    flt_bypass = 1'b1;
    idle(3);
    enc_sig[0] = 1'b1;
    src_sel[1:0] = 2'b10;
    expect_pulse(0, BYP_PULSE);
    idle(2);
    check_val("R1 ch0 encoder phase A", 32'(level[0]), 32'h1);
    idle(4);
    enc_sig[1] = 1'b1;
    src_sel[3:2] = 2'b10;
    idle(2);
    check_val("R1 ch1 encoder phase B", 32'(level[1]), 32'h1);
    idle(4);
    enc_sig[0] = 1'b0;
    expect_pulse(0, BYP_PULSE);
    idle(2);
    check_val("R1 ch1 ignores phase A", 32'(level[1:0]), 32'h2);
    idle(4);
    pin_in[0]  = 1'b1;
    enc_sig[0] = 1'b1;
    src_sel[1:0] = 2'b01;
    idle(4);
    check_val("R1 reserved 01 forces 0", 32'(level[0]), 32'h0);
    src_sel[1:0] = 2'b11;
    idle(4);
    check_val("R1 reserved 11 forces 0", 32'(level[0]), 32'h0);
    enc_sig[2] = 1'b1;
    src_sel[5:4] = 2'b10;
    expect_pulse(2, BYP_PULSE);
    idle(2);
    check_val("R1 ch2 encoder index", 32'(level[2]), 32'h1);
    idle(4);
    src_sel[3:2] = 2'b11;
    expect_pulse(1, BYP_PULSE);
    idle(2);
    check_val("R1 ch1 reserved drops level", 32'(level[1]), 32'h0);
    idle(4);
    pin_in  = '0;
    enc_sig = '0;
    src_sel = '0;
    expect_pulse(2, BYP_PULSE);
    idle(6);

    // R6: disabled channels give no pulse, level still tracks
    ch_en  = '0;
    pin_in = 3'b111;
    idle(2);
    check_val("R6 level tracks while disabled", 32'(level), 32'h7);
    idle(4);
    pin_in = 3'b000;
    idle(2);
    check_val("R6 level falls while disabled", 32'(level), 32'h0);
    idle(4);

    // R2: filter delay window for every rate code (channel disabled)
    flt_bypass = 1'b0;
    for (int code = 0; code < 8; code++) begin
      int d;
      int lat;
      d = bench_div(code);
      flt_rate = 3'(code);
      idle(2);
      pin_in[0] = 1'b1;
      lat = 0;
      do begin
        idle(1);
        lat++;
      end while (level[0] !== 1'b1 && lat < 400);
      n_vec++;
      if (lat < 2*d + 3 || lat > 3*d + 2) begin
        n_bad++;
        $display("FAIL R2: code %0d delay actual %0d expected %0d..%0d", code, lat, 2*d + 3, 3*d + 2);
      end
      pin_in[0] = 1'b0;
      idle(3*d + 4);
      check_val("R2 level returns low", 32'(level[0]), 32'h0);
    end
    ch_en = '1;
    idle(10);

    check_val("R7 all expected pulses seen", 32'(exp_q.size()), 32'h0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule